// File: doc/BRIEF.md
# Jump-Counter Microsequencer with Opcode Dispatch

This block sequences the register transfers of a small multicycle processor. A 4-bit micro-program counter holds the current control step. On every clock it takes exactly one of three actions, chosen by the current step: it clears to step 0, advances by one, or loads a target from a constant dispatch table. The instruction class selects the table entry, and for a branch the equality flag picks between two outcome steps.

Each step drives a fixed set of datapath strobes, one per register transfer: instruction load, operand latch, one of three ALU functions, memory read or write, one of three register-file writes, and one of two program-counter updates. Every instruction starts with a fetch step and a decode step. From decode the table sends it to its own short run of steps, which always ends with a clear back to fetch. The datapath, memory and register file sit outside the block. The block sees only the instruction class code and the equality flag, and shows its state and its strobes.

Top module: `useq_ctrl`

## Requirements
- R1: A high `rst` at a rising clock edge sets `upc` to 0000 after that edge, from any step, including the middle of an instruction.
- R2: Step 0000 (fetch) always advances to 0001 and drives only `strb[0]` (instruction load).
- R3: Step 0001 (decode) drives only `strb[1]` (operand latch) and loads the next step from the dispatch table using `op_cls`: 0 (register-register) gives 0100, 1 (OR-immediate) gives 0110, 2 (load) gives 1000, 3 (store) gives 1011, and 4 (branch-if-equal) is covered by R8.
- R4: Register-register path: 0100 drives only `strb[2]` (ALU function field), then 0101 drives `strb[7]` (write rd) and `strb[10]` (PC+4), then the next step is 0000.
- R5: OR-immediate path: 0110 drives only `strb[3]` (ALU OR with zero-extended immediate), then 0111 drives `strb[8]` (write rt from ALU) and `strb[10]`, then the next step is 0000.
- R6: Load path: 1000 drives only `strb[4]` (ALU address add), then 1001 drives only `strb[5]` (memory read), then 1010 drives `strb[9]` (write rt from memory) and `strb[10]`, then the next step is 0000.
- R7: Store path: 1011 drives only `strb[4]`, then 1100 drives `strb[6]` (memory write) and `strb[10]`, then the next step is 0000.
- R8: Branch-if-equal: from 0001 with `op_cls` = 4, the next step is 0011 if `eq_flag` is 1, and 0011 drives only `strb[11]` (PC gets the branch target). If `eq_flag` is 0, the next step is 0010, which drives only `strb[10]`. Either step then goes to 0000.
- R9: `eq_flag` has no effect on the step sequence except in step 0001 with `op_cls` = 4.
- R10: Class codes 5, 6 and 7 make step 0001 load 0000, so the machine fetches again.
- R11: No step drives more than one of these groups' members at a time: {`strb[0]`, `strb[5]`, `strb[6]`} on the memory bus, {`strb[7]`, `strb[8]`, `strb[9]`} on the register write port, {`strb[2]`, `strb[3]`, `strb[4]`} for the ALU, and {`strb[10]`, `strb[11]`} for the PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_cls | input | 3 | Instruction class code from the instruction register |
| eq_flag | input | 1 | Operand equality flag from the datapath |
| upc | output | 4 | Current micro-program step |
| strb | output | 12 | Register-transfer strobes, one bit per transfer |

## Verification
The bench walks every instruction class through fetch, decode and its own path. It checks the step and the complete strobe word in each cycle, so a wrong table entry or a wrong increment-versus-clear choice shows up as a step out of order or a stray strobe. The branch runs with both flag values. A sequencer that read the flag outside the dispatch cycle, or ignored it there, would land in the wrong outcome step. One run toggles the flag on every other cycle to expose that. The unused class codes are driven to catch a design that hangs or jumps into a stale path. A reset in the middle of a load must return the machine to fetch on the very next edge.

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int UPC_W  = 4,
  parameter int OP_W   = 3,
  parameter int STRB_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_cls,
  input  logic              eq_flag,
  output logic [UPC_W-1:0]  upc,
  output logic [STRB_W-1:0] strb
);

  localparam logic [UPC_W-1:0] S_FETCH = UPC_W'(0);
  localparam logic [UPC_W-1:0] S_DEC   = UPC_W'(1);
  localparam logic [UPC_W-1:0] S_BNE   = UPC_W'(2);
  localparam logic [UPC_W-1:0] S_BEQ   = UPC_W'(3);
  localparam logic [UPC_W-1:0] S_REX   = UPC_W'(4);
  localparam logic [UPC_W-1:0] S_RWB   = UPC_W'(5);
  localparam logic [UPC_W-1:0] S_OEX   = UPC_W'(6);
  localparam logic [UPC_W-1:0] S_OWB   = UPC_W'(7);
  localparam logic [UPC_W-1:0] S_LADR  = UPC_W'(8);
  localparam logic [UPC_W-1:0] S_LMEM  = UPC_W'(9);
  localparam logic [UPC_W-1:0] S_LWB   = UPC_W'(10);
  localparam logic [UPC_W-1:0] S_SADR  = UPC_W'(11);
  localparam logic [UPC_W-1:0] S_SMEM  = UPC_W'(12);

  localparam logic [OP_W-1:0] C_RR  = OP_W'(0);
  localparam logic [OP_W-1:0] C_ORI = OP_W'(1);
  localparam logic [OP_W-1:0] C_LD  = OP_W'(2);
  localparam logic [OP_W-1:0] C_ST  = OP_W'(3);
  localparam logic [OP_W-1:0] C_BR  = OP_W'(4);

  localparam int B_IR = 0, B_OPND = 1, B_FUN = 2, B_OR = 3, B_ADD = 4, B_MRD = 5,
                 B_MWR = 6, B_WRD = 7, B_WRTA = 8, B_WRTM = 9, B_PCSQ = 10, B_PCBR = 11;

  typedef enum logic [1:0] {ACT_ZERO, ACT_INC, ACT_LOAD} act_t;

  act_t             act;
  logic [UPC_W-1:0] map_tgt;
  logic [UPC_W-1:0] upc_nxt;

  function automatic logic [UPC_W-1:0] map_lookup(input logic [OP_W-1:0] c, input logic tk);
    case (c)
      C_RR:    return S_REX;
      C_ORI:   return S_OEX;
      C_LD:    return S_LADR;
      C_ST:    return S_SADR;
      C_BR:    return tk ? S_BEQ : S_BNE;
      default: return S_FETCH;
    endcase
  endfunction

  assign map_tgt = map_lookup(op_cls, eq_flag);

  always_comb begin
    case (upc)
      S_FETCH, S_REX, S_OEX, S_LADR, S_LMEM, S_SADR: act = ACT_INC;
      S_DEC:                                          act = ACT_LOAD;
      default:                                        act = ACT_ZERO;
    endcase
  end

  always_comb begin
    case (act)
      ACT_INC:  upc_nxt = upc + UPC_W'(1);
      ACT_LOAD: upc_nxt = map_tgt;
      default:  upc_nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= S_FETCH;
    else     upc <= upc_nxt;
  end

  always_comb begin
    strb = '0;
    case (upc)
      S_FETCH: strb[B_IR]   = 1'b1;
      S_DEC:   strb[B_OPND] = 1'b1;
      S_REX:   strb[B_FUN]  = 1'b1;
      S_RWB:   begin strb[B_WRD]  = 1'b1; strb[B_PCSQ] = 1'b1; end
      S_OEX:   strb[B_OR]   = 1'b1;
      S_OWB:   begin strb[B_WRTA] = 1'b1; strb[B_PCSQ] = 1'b1; end
      S_LADR:  strb[B_ADD]  = 1'b1;
      S_LMEM:  strb[B_MRD]  = 1'b1;
      S_LWB:   begin strb[B_WRTM] = 1'b1; strb[B_PCSQ] = 1'b1; end
      S_SADR:  strb[B_ADD]  = 1'b1;
      S_SMEM:  begin strb[B_MWR]  = 1'b1; strb[B_PCSQ] = 1'b1; end
      S_BNE:   strb[B_PCSQ] = 1'b1;
      S_BEQ:   strb[B_PCBR] = 1'b1;
      default: strb = '0;
    endcase
  end

  AST_RESET_TO_FETCH: assert property (@(posedge clk) rst |=> upc == S_FETCH); // R1
  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
    upc == S_FETCH |=> upc == S_DEC); // R2
  AST_BRANCH_PICK: assert property (@(posedge clk) disable iff (rst)
    (upc == S_DEC && op_cls == C_BR) |=> upc == ($past(eq_flag) ? S_BEQ : S_BNE)); // R8
  AST_UNKNOWN_REFETCH: assert property (@(posedge clk) disable iff (rst)
    (upc == S_DEC && op_cls > C_BR) |=> upc == S_FETCH); // R10
  AST_PC_STEP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (strb[B_PCSQ] || strb[B_PCBR]) |=> upc == S_FETCH); // R8
  AST_MEM_BUS_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb[B_IR], strb[B_MRD], strb[B_MWR]})); // R11
  AST_REG_WR_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb[B_WRD], strb[B_WRTA], strb[B_WRTM]})); // R11
  AST_ALU_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb[B_FUN], strb[B_OR], strb[B_ADD]})); // R11
  AST_PC_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb[B_PCSQ], strb[B_PCBR]})); // R11

endmodule

// File: tb/useq_ctrl_tb.sv
module useq_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_cls = '0;
  logic        eq_flag = 1'b0;
  logic [3:0]  upc;
  logic [11:0] strb;

  int checks = 0;
  int errors = 0;

  useq_ctrl u_dut (.clk(clk), .rst(rst), .op_cls(op_cls), .eq_flag(eq_flag), .upc(upc), .strb(strb));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [11:0] exp_strb(input logic [3:0] s);
    case (s)
      4'd0:  return 12'b0000_0000_0001;
      4'd1:  return 12'b0000_0000_0010;
      4'd4:  return 12'b0000_0000_0100;
      4'd5:  return 12'b0100_1000_0000;
      4'd6:  return 12'b0000_0000_1000;
      4'd7:  return 12'b0101_0000_0000;
      4'd8:  return 12'b0000_0001_0000;
      4'd9:  return 12'b0000_0010_0000;
      4'd10: return 12'b0110_0000_0000;
      4'd11: return 12'b0000_0001_0000;
      4'd12: return 12'b0100_0100_0000;
      4'd2:  return 12'b0100_0000_0000;
      4'd3:  return 12'b1000_0000_0000;
      default: return 12'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // seq: up to 6 steps packed low nibble first, n steps; noise toggles eq outside dispatch
  task automatic run_instr(input string req, input logic [2:0] op, input logic eq,
                           input logic [23:0] seq, input int n, input bit noise);
    op_cls = op;
    for (int i = 0; i < n; i++) begin
      logic [3:0] es;
      es = seq[i*4 +: 4];
      if (noise) eq_flag = (es == 4'd1) ? eq : ~eq_flag;
      else       eq_flag = eq;
      chk(upc == es, req, upc, es);
      chk(strb == exp_strb(es), req, strb, exp_strb(es));
      step();
    end
    chk(upc == 4'd0, req, upc, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step();
    chk(upc == 4'd0, "R1", upc, 0);
    chk(strb == 12'h001, "R2", strb, 12'h001);
    rst = 1'b0;
  endtask

  task automatic t_rtype();  run_instr("R4", 3'd0, 1'b0, 24'h00_5410, 4, 1'b0); endtask
  task automatic t_ori();    run_instr("R5", 3'd1, 1'b1, 24'h00_7610, 4, 1'b0); endtask
  task automatic t_load();   run_instr("R6", 3'd2, 1'b0, 24'h0A_9810, 5, 1'b0); endtask
  task automatic t_store();  run_instr("R7", 3'd3, 1'b1, 24'h00_CB10, 4, 1'b0); endtask
  task automatic t_br_tk();  run_instr("R8", 3'd4, 1'b1, 24'h00_0310, 3, 1'b0); endtask
  task automatic t_br_nt();  run_instr("R8", 3'd4, 1'b0, 24'h00_0210, 3, 1'b0); endtask

  task automatic t_eq_noise();
    run_instr("R9", 3'd2, 1'b1, 24'h0A_9810, 5, 1'b1);
    run_instr("R9", 3'd4, 1'b0, 24'h00_0210, 3, 1'b1);
    run_instr("R9", 3'd4, 1'b1, 24'h00_0310, 3, 1'b1);
    run_instr("R9", 3'd0, 1'b1, 24'h00_5410, 4, 1'b1);
  endtask

  task automatic t_unknown();
    for (int c = 5; c < 8; c++) run_instr("R10", 3'(c), 1'b1, 24'h00_0010, 2, 1'b0);
  endtask

  task automatic t_dispatch_all();
    for (int c = 0; c < 4; c++) begin
      logic [3:0] tgt;
      tgt = (c == 0) ? 4'd4 : (c == 1) ? 4'd6 : (c == 2) ? 4'd8 : 4'd11;
      op_cls = 3'(c);
      chk(upc == 4'd0, "R3", upc, 0);
      step();
      chk(upc == 4'd1 && strb == 12'h002, "R3", {strb, upc}, {12'h002, 4'd1});
      step();
      chk(upc == tgt, "R3", upc, tgt);
      rst = 1'b1; step(); rst = 1'b0;
    end
  endtask

  task automatic t_mid_reset();
    op_cls = 3'd2; eq_flag = 1'b0;
    step(); step(); step();
    chk(upc == 4'd9, "R6", upc, 9);
    rst = 1'b1; step(); rst = 1'b0;
    chk(upc == 4'd0, "R1", upc, 0);
    chk(strb == 12'h001, "R1", strb, 12'h001);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_rtype();
    t_ori();
    t_load();
    t_store();
    t_br_tk();
    t_br_nt();
    t_eq_noise();
    t_unknown();
    t_dispatch_all();
    t_mid_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule